// File: doc/BRIEF.md
# Skew-Corrected Return Address Stack

This block predicts the targets of subroutine returns for a short in-order pipeline. Fetch uses the prediction while it fills the instruction queue. Decode resolves branches, and only decode changes the stack. Calls push their return address at decode, and returns pop at decode. Because of this, instructions fetched down a wrong path never touch the stored addresses or the committed top-of-stack pointer.

Fetch runs ahead of decode. A return that fetch has already predicted has therefore not yet moved the committed pointer. A small signed offset covers this gap. It goes down by one for each return predicted in fetch and up by one for each return that reaches decode. Fetch reads the slot at (top-of-stack − 1 + offset), taken modulo the depth. A decode redirect clears the offset and leaves the stack itself as it was.

The storage is a circular buffer whose depth is a power of two. When more calls arrive than there are slots, the oldest slot is overwritten. Returns of the link-register and pop-to-PC kind are predicted. Register-indirect jumps are not handled here.

Top module: `ras_skew_top`

## Requirements
- R1: After reset the stack holds no valid entries and the offset is zero, so a return seen in fetch gets predValid low.
- R2: A call committed at decode stores its PC plus 2 and advances the top-of-stack. With no returns in flight, the next return seen in fetch predicts that address with predValid high.
- R3: Returns seen in fetch in successive cycles, with no decode activity, read successively older entries. The k-th in-flight return reads slot (top-of-stack − k) modulo the depth.
- R4: A return committed at decode moves the top-of-stack down by one and removes one in-flight prediction from the offset, so later predictions still read the right entry.
- R5: predValid is high only when a return is seen in fetch and the number of valid entries is greater than the number of returns already in flight.
- R6: A flush clears the offset to zero and leaves the top-of-stack pointer and the stored addresses unchanged.
- R7: When a call commits in the same cycle as a fetch-side read, the read returns the value from before the push.
- R8: A call into a full stack overwrites the oldest slot, and the valid-entry count stays at the depth.
- R9: A return committed at decode on an empty stack wraps the top-of-stack pointer down by one and leaves the valid count at zero.
- R10: A return committed at decode while no prediction is in flight leaves the offset at zero; the offset is never positive.
- R11: A return seen in fetch and a return committed at decode in the same cycle leave the offset unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchRetValid | input | 1 | A return was detected while filling the queue in fetch |
| decCallValid | input | 1 | A call commits at decode |
| decCallPc | input | ADDR_W | PC of the committing call |
| decRetValid | input | 1 | A return commits at decode |
| decFlush | input | 1 | Decode redirect that drops the in-flight instructions |
| predTarget | output | ADDR_W | Predicted return address |
| predValid | output | 1 | predTarget may be used this cycle |

## Verification
The bench builds the block with the default depth of 4 and a 32-bit address. With only four slots, five calls are enough to reach the wrap-around overwrite and the saturated count, and four in-flight returns are enough to reach the point where predValid drops. The small depth also keeps the pointer wrap on an empty stack close at hand. In the same way, a short sequence reaches the offset arithmetic for simultaneous fetch and decode returns, together with the flush recovery.

// File: rtl/ras_skew_pkg.sv
package ras_skew_pkg;
  // Commit strobes from the control half to the storage half.
  typedef struct packed {
    logic push;
    logic pop;
  } rasStrobe_t;
endpackage

// File: rtl/ras_skew_ctrl.sv
module ras_skew_ctrl
  import ras_skew_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                                        clk,
  input  logic                                        rstN,
  input  logic                                        fetchRetValid,
  input  logic                                        decCallValid,
  input  logic                                        decRetValid,
  input  logic                                        decFlush,
  output rasStrobe_t                                  strobe,
  output logic signed [$clog2(DEPTH)+1:0]             offsetQ,
  output logic [$clog2(DEPTH+1)-1:0]                  entryCount,
  output logic                                        predValid
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int OFF_W = PTR_W + 2;
  localparam logic signed [OFF_W-1:0] OFF_MIN = OFF_W'(1 - (2 ** (OFF_W - 1)));
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic signed [OFF_W-1:0] offNext;
  logic [CNT_W-1:0]        cntNext;
  logic                    fetchDec;
  logic                    retInc;
  logic signed [OFF_W:0]   margin;

  // A call wins if both commit strobes appear together.
  assign strobe.push = decCallValid;
  assign strobe.pop  = decRetValid && !decCallValid;

  assign fetchDec = fetchRetValid && (offsetQ > OFF_MIN);
  assign retInc   = decRetValid && (offsetQ < 0);

  always_comb begin
    offNext = offsetQ;
    if (decFlush) begin
      offNext = '0;
    end else if (fetchDec && !retInc) begin
      offNext = offsetQ - OFF_W'(1);
    end else if (!fetchDec && retInc) begin
      offNext = offsetQ + OFF_W'(1);
    end
  end

  always_comb begin
    cntNext = entryCount;
    if (strobe.push && entryCount != CNT_MAX) begin
      cntNext = entryCount + CNT_W'(1);
    end else if (strobe.pop && entryCount != '0) begin
      cntNext = entryCount - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offsetQ    <= '0;
      entryCount <= '0;
    end else begin
      offsetQ    <= offNext;
      entryCount <= cntNext;
    end
  end

  // Entries left beyond the returns already in flight.
  assign margin    = $signed({1'b0, {(OFF_W - CNT_W){1'b0}}, entryCount})
                   + $signed({offsetQ[OFF_W-1], offsetQ});
  assign predValid = fetchRetValid && (margin > 0);
endmodule

// File: rtl/ras_skew_dp.sv
module ras_skew_dp
  import ras_skew_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  rasStrobe_t                          strobe,
  input  logic [ADDR_W-1:0]                   pushPc,
  input  logic signed [$clog2(DEPTH)+1:0]     offset,
  output logic [ADDR_W-1:0]                   predTarget,
  output logic [$clog2(DEPTH)-1:0]            tosQ
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int OFF_W = PTR_W + 2;

  logic [ADDR_W-1:0] slots [DEPTH];
  logic [OFF_W-1:0]  sumRaw;
  logic [PTR_W-1:0]  readIdx;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slots[i] <= '0;
      end else if (strobe.push && tosQ == PTR_W'(i)) begin
        slots[i] <= pushPc + ADDR_W'(2);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tosQ <= '0;
    end else if (strobe.push) begin
      tosQ <= tosQ + PTR_W'(1);
    end else if (strobe.pop) begin
      tosQ <= tosQ - PTR_W'(1);
    end
  end

  // Modulo-depth index from committed top plus the in-flight skew.
  assign sumRaw     = {{(OFF_W - PTR_W){1'b0}}, tosQ} + $unsigned(offset) - OFF_W'(1);
  assign readIdx    = sumRaw[PTR_W-1:0];
  assign predTarget = slots[readIdx];
endmodule

// File: rtl/ras_skew_top.sv
module ras_skew_top
  import ras_skew_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchRetValid,
  input  logic              decCallValid,
  input  logic [ADDR_W-1:0] decCallPc,
  input  logic              decRetValid,
  input  logic              decFlush,
  output logic [ADDR_W-1:0] predTarget,
  output logic              predValid
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int OFF_W = PTR_W + 2;

  rasStrobe_t              strobe;
  logic signed [OFF_W-1:0] offsetQ;
  logic [CNT_W-1:0]        entryCount;
  logic [PTR_W-1:0]        tosQ;

  ras_skew_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .fetchRetValid(fetchRetValid), .decCallValid(decCallValid),
    .decRetValid(decRetValid), .decFlush(decFlush),
    .strobe(strobe), .offsetQ(offsetQ), .entryCount(entryCount),
    .predValid(predValid)
  );

  ras_skew_dp #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pushPc(decCallPc),
    .offset(offsetQ), .predTarget(predTarget), .tosQ(tosQ)
  );
endmodule

// File: rtl/ras_skew_chk.sv
module ras_skew_chk #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32
) (
  input logic                                    clk,
  input logic                                    rstN,
  input logic                                    fetchRetValid,
  input logic                                    decCallValid,
  input logic [ADDR_W-1:0]                       decCallPc,
  input logic                                    decRetValid,
  input logic                                    decFlush,
  input logic [ADDR_W-1:0]                       predTarget,
  input logic                                    predValid,
  input logic [$clog2(DEPTH)-1:0]                tosQ,
  input logic signed [$clog2(DEPTH)+1:0]         offsetQ,
  input logic [$clog2(DEPTH+1)-1:0]              entryCount
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int OFF_W = PTR_W + 2;
  localparam logic signed [OFF_W-1:0] OFF_MIN = OFF_W'(1 - (2 ** (OFF_W - 1)));

  // R2
  call_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decCallValid && offsetQ == 0 && !fetchRetValid && !decFlush)
    |=> (!fetchRetValid || (predValid && predTarget == $past(decCallPc) + ADDR_W'(2))));

  // R4
  pop_tos_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decRetValid && !decCallValid) |=> tosQ == $past(tosQ) - PTR_W'(1));

  // R5
  pred_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    predValid |-> (fetchRetValid && entryCount != 0));

  // R6
  flush_keeps_tos_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decFlush && !decCallValid && !decRetValid) |=> (offsetQ == 0 && $stable(tosQ)));

  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    entryCount <= ($clog2(DEPTH + 1))'(DEPTH));

  // R10
  offset_nonpos_chk: assert property (@(posedge clk) disable iff (!rstN)
    offsetQ <= 0);

  // R11
  same_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fetchRetValid && decRetValid && !decFlush && offsetQ < 0 && offsetQ > OFF_MIN)
    |=> $stable(offsetQ));
endmodule

bind ras_skew_top ras_skew_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .fetchRetValid(fetchRetValid),
  .decCallValid(decCallValid), .decCallPc(decCallPc),
  .decRetValid(decRetValid), .decFlush(decFlush),
  .predTarget(predTarget), .predValid(predValid),
  .tosQ(tosQ), .offsetQ(offsetQ), .entryCount(entryCount)
);

// File: tb/ras_skew_top_tb_top.sv
module ras_skew_top_tb_top;
  localparam int DEPTH  = 4;
  localparam int ADDR_W = 32;

  typedef struct packed {
    logic        fetch;
    logic        call;
    logic [31:0] pc;
    logic        ret;
    logic        flush;
    logic        chk;
    logic        expV;
    logic [31:0] expT;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 31;
  localparam vec_t TABLE [NVEC] = '{
    '{1'b1, 1'b0, 32'h0,   1'b0, 1'b0, 1'b1, 1'b0, 32'h0,   8'd1},  // 0  R1 empty after reset
    '{1'b0, 1'b0, 32'h0,   1'b0, 1'b1, 1'b0, 1'b0, 32'h0,   8'd6},  // 1  flush
    '{1'b0, 1'b1, 32'h100, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,   8'd2},  // 2  call
    '{1'b0, 1'b1, 32'h200, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,   8'd2},  // 3  call
    '{1'b0, 1'b1, 32'h300, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,   8'd2},  // 4  call
    '{1'b1, 1'b0, 32'h0,   1'b0, 1'b0, 1'b1, 1'b1, 32'h302, 8'd2},  // 5  R2 top entry
    '{1'b1, 1'b0, 32'h0,   1'b0, 1'b0, 1'b1, 1'b1, 32'h202, 8'd3},  // 6  R3 second in flight
    '{1'b1, 1'b0, 32'h0,   1'b0, 1'b0, 1'b1, 1'b1, 32'h102, 8'd3},  // 7  R3 third in flight
    '{1'b1, 1'b0, 32'h0,   1'b0, 1'b0, 1'b1, 1'b0, 32'h0,   8'd5},  // 8  R5 more in flight than entries
    '{1'b0, 1'b0, 32'h0,   1'b0, 1'b1, 1'b0, 1'b0, 32'h0,   8'd6},  // 9  flush
    '{1'b1, 1'b0, 32'h0,   1'b0, 1'b0, 1'b1, 1'b1, 32'h302, 8'd6},  // 10 R6 top again
    '{1'b0, 1'b0, 32'h0,   1'b1, 1'b0, 1'b0, 1'b0, 32'h0,   8'd4},  // 11 decode return
    '{1'b1, 1'b0, 32'h0,   1'b0, 1'b0, 1'b1, 1'b1, 32'h202, 8'd4},  // 12 R4
    '{1'b1, 1'b0, 32'h0,   1'b1, 1'b0, 1'b1, 1'b1, 32'h102, 8'd11}, // 13 R11 fetch+decode
    '{1'b0, 1'b1, 32'h600, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,   8'd11}, // 14 call
    '{1'b1, 1'b0, 32'h0,   1'b0, 1'b0, 1'b1, 1'b1, 32'h102, 8'd11}, // 15 R11 offset still -1
    '{1'b0, 1'b0, 32'h0,   1'b0, 1'b1, 1'b0, 1'b0, 32'h0,   8'd6},  // 16 flush
    '{1'b0, 1'b0, 32'h0,   1'b1, 1'b0, 1'b0, 1'b0, 32'h0,   8'd4},  // 17 return
    '{1'b0, 1'b0, 32'h0,   1'b1, 1'b0, 1'b0, 1'b0, 32'h0,   8'd4},  // 18 return
    '{1'b1, 1'b0, 32'h0,   1'b0, 1'b0, 1'b1, 1'b0, 32'h0,   8'd5},  // 19 R5 empty again
    '{1'b0, 1'b0, 32'h0,   1'b0, 1'b1, 1'b0, 1'b0, 32'h0,   8'd6},  // 20 flush
    '{1'b0, 1'b0, 32'h0,   1'b1, 1'b0, 1'b0, 1'b0, 32'h0,   8'd9},  // 21 return on empty
    '{1'b1, 1'b0, 32'h0,   1'b0, 1'b0, 1'b1, 1'b0, 32'h0,   8'd9},  // 22 R9 count stays 0
    '{1'b0, 1'b0, 32'h0,   1'b0, 1'b1, 1'b0, 1'b0, 32'h0,   8'd6},  // 23 flush
    '{1'b0, 1'b1, 32'h400, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,   8'd9},  // 24 call into wrapped slot
    '{1'b1, 1'b0, 32'h0,   1'b0, 1'b0, 1'b1, 1'b1, 32'h402, 8'd9},  // 25 R9 pointer wrapped
    '{1'b0, 1'b0, 32'h0,   1'b0, 1'b1, 1'b0, 1'b0, 32'h0,   8'd6},  // 26 flush
    '{1'b0, 1'b1, 32'h500, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,   8'd10}, // 27 call
    '{1'b0, 1'b0, 32'h0,   1'b1, 1'b0, 1'b0, 1'b0, 32'h0,   8'd10}, // 28 return, nothing in flight
    '{1'b1, 1'b0, 32'h0,   1'b0, 1'b0, 1'b1, 1'b1, 32'h402, 8'd10}, // 29 R10 offset stayed 0
    '{1'b0, 1'b0, 32'h0,   1'b0, 1'b1, 1'b0, 1'b0, 32'h0,   8'd6}   // 30 flush
  };

  logic              clk = 1'b0;
  logic              rstN;
  logic              fetchRetValid;
  logic              decCallValid;
  logic [ADDR_W-1:0] decCallPc;
  logic              decRetValid;
  logic              decFlush;
  logic [ADDR_W-1:0] predTarget;
  logic              predValid;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  ras_skew_top #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .fetchRetValid(fetchRetValid),
    .decCallValid(decCallValid), .decCallPc(decCallPc),
    .decRetValid(decRetValid), .decFlush(decFlush),
    .predTarget(predTarget), .predValid(predValid)
  );

  task automatic step(input logic f, input logic c, input logic [31:0] pc,
                      input logic r, input logic fl, input logic chk,
                      input logic ev, input logic [31:0] et, input string tag);
    @(negedge clk);
    fetchRetValid = f;
    decCallValid  = c;
    decCallPc     = pc;
    decRetValid   = r;
    decFlush      = fl;
    #1;
    if (chk) begin
      checks++;
      if (predValid !== ev || (ev && predTarget !== et)) begin
        errors++;
        $display("FAIL %s: predValid=%0b predTarget=%h, expected predValid=%0b predTarget=%h",
                 tag, predValid, predTarget, ev, et);
      end
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    fetchRetValid = 1'b0;
    decCallValid = 1'b0;
    decCallPc = '0;
    decRetValid = 1'b0;
    decFlush = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    fetchRetValid = 1'b0;
    decCallValid = 1'b0;
    decCallPc = '0;
    decRetValid = 1'b0;
    decFlush = 1'b0;
    doReset();

    for (int i = 0; i < NVEC; i++) begin
      step(TABLE[i].fetch, TABLE[i].call, TABLE[i].pc, TABLE[i].ret, TABLE[i].flush,
           TABLE[i].chk, TABLE[i].expV, TABLE[i].expT, $sformatf("R%0d", TABLE[i].req));
    end

    // R8: five calls into four slots, then walk all in-flight reads.
    doReset();
    step(1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0, "R1");
    step(1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0, "R6");
    for (int k = 1; k <= 5; k++) begin
      step(1'b0, 1'b1, 32'(k * 16), 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, "R8");
    end
    step(1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h52, "R8");
    step(1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h42, "R8");
    step(1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h32, "R8");
    step(1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h22, "R8");
    step(1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0,  "R8");
    step(1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0,  "R6");

    // R7: push and fetch read in the same cycle.
    doReset();
    step(1'b0, 1'b1, 32'h700, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, "R7");
    step(1'b1, 1'b1, 32'h800, 1'b0, 1'b0, 1'b1, 1'b1, 32'h702, "R7");
    step(1'b0, 1'b0, 32'h0,   1'b0, 1'b1, 1'b0, 1'b0, 32'h0,   "R6");
    step(1'b1, 1'b0, 32'h0,   1'b0, 1'b0, 1'b1, 1'b1, 32'h802, "R7");
    step(1'b0, 1'b0, 32'h0,   1'b0, 1'b1, 1'b0, 1'b0, 32'h0,   "R6");

    // R1: reset with a loaded stack empties it.
    doReset();
    step(1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0, "R1");
    step(1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, "R1");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule